// File: doc/BRIEF.md
# Fixed-Point Logarithm Pipeline

This block turns a positive unsigned fixed-point value into an approximate logarithm. It first finds the position of the most significant set bit, which becomes the integer exponent. It then shifts the value so that this bit sits just above the binary point, giving a mantissa in [1,2). A cubic in the mantissa is evaluated in nested form, with one multiply and one add per pipeline stage. The exponent, scaled by a programmable per-octave constant, is then added to that result. The precision in use is about four to five significant decimal figures.

All five constants are registers that software writes: the four polynomial coefficients and the per-octave constant. Fitting them to a base (natural, binary or decimal) is the caller's task. One sample is accepted per clock and one result leaves per clock, a fixed number of cycles later. A zero input has no logarithm, so the result for a zero input carries an error flag and a saturated value.

Top module: `logu_log_unit`

## Requirements
- R1: For a non-zero input x, the exponent e is the index of the highest set bit. The mantissa is m = x·2^(12−e) read as unsigned Q1.12, so 2^12 ≤ m < 2^13. A power-of-two input gives m = 1.0 exactly.
- R2: Coefficients are signed 18-bit values with 12 fraction bits. The mantissa term is computed as t1 = rnd(d·m)+c, t2 = rnd(t1·m)+b, t3 = rnd(t2·m)+a. Here rnd(p) = floor((p + 2^11) / 2^12), which rounds half upward back to 12 fraction bits.
- R3: The result is t3 + e·k, where k is the per-octave constant. The scaled exponent is added only when e ≠ 0, so an input of 1 yields t3 alone.
- R4: An input of zero gives out_err = 1 and out_data = −2^22, the most negative 23-bit value.
- R5: A sample presented with in_valid high on one rising edge appears with out_valid high exactly 5 rising edges later. Samples on consecutive cycles produce results on consecutive cycles.
- R6: While out_valid is low, out_data is 0 and out_err is 0.
- R7: A write with cfg_we high loads cfg_data into the constant named by cfg_sel: 0 = a, 1 = b, 2 = c, 3 = d, 4 = k. Selector codes 5, 6 and 7 change no constant. Constants may only be written while no sample is in flight.
- R8: Synchronous reset clears out_valid and all five constants to zero, so a non-zero input after reset gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 12 | Unsigned input value |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sel | input | 3 | Constant selector (0 a, 1 b, 2 c, 3 d, 4 k) |
| cfg_data | input | 18 | Signed constant, 12 fraction bits |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 23 | Signed result, 12 fraction bits |
| out_err | output | 1 | Zero input marker |

## Verification
The hardest case to reach is an intermediate Horner sum near its width limit, where a wrong guard width or a wrong sign extension would wrap silently. The bench reaches it by loading full-scale constants of alternating sign. It then sweeps every input code, so every mantissa up to just below 2.0 meets those extremes. A second exhaustive sweep with a realistic constant set checks the rounding on ordinary values. Writes with the unused selector codes are followed by a stream whose results must still match the earlier constants.

// File: rtl/logu_pkg.sv
package logu_pkg;

    // Input width, working fraction width and constant width
    localparam int IN_W = 12;
    localparam int FW   = 12;
    localparam int CW   = 18;

    // Derived sizes
    localparam int EW    = $clog2(IN_W);
    localparam int MW    = FW + 1;          // mantissa, unsigned Q1.FW
    localparam int AW    = CW + 4;          // Horner accumulator with growth guard
    localparam int RW    = CW + 5;          // final result width
    localparam int PW    = AW + MW + 1;     // full product width
    localparam int LAT   = 5;               // normaliser + 3 Horner + combine
    localparam int CNT_W = $clog2(LAT + 1);

    typedef logic        [EW-1:0] exp_t;
    typedef logic        [MW-1:0] mant_t;
    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [RW-1:0] res_t;
    typedef logic signed [PW-1:0] prod_t;

    localparam res_t  RES_MIN  = {1'b1, {(RW-1){1'b0}}};
    localparam prod_t RND_HALF = PW'(2 ** (FW-1));

    typedef enum logic [2:0] {
        SEL_A = 3'd0,
        SEL_B = 3'd1,
        SEL_C = 3'd2,
        SEL_D = 3'd3,
        SEL_K = 3'd4
    } coef_sel_e;

    typedef struct packed {
        coef_t a;
        coef_t b;
        coef_t c;
        coef_t d;
        coef_t k;
    } coef_set_t;

    typedef struct packed {
        logic  vld;
        logic  zero;
        exp_t  ex;
        mant_t mant;
        acc_t  acc;
    } pipe_t;

    // Round a full product half-up back to FW fraction bits (full width kept)
    function automatic prod_t round_shift(input prod_t p);
        prod_t t;
        t = p + RND_HALF;
        return t >>> FW;
    endfunction

endpackage

// File: rtl/logu_coef_bank.sv
module logu_coef_bank
    import logu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [2:0] sel,
    input  coef_t      wdata,
    output coef_set_t  coefs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            coefs <= '0;
        end else if (we) begin
            case (sel)
                SEL_A:   coefs.a <= wdata;
                SEL_B:   coefs.b <= wdata;
                SEL_C:   coefs.c <= wdata;
                SEL_D:   coefs.d <= wdata;
                SEL_K:   coefs.k <= wdata;
                default: ;
            endcase
        end
    end

    // R7: a write lands in the selected constant
    a_r7_write_a: assert property (@(posedge clk) disable iff (rst)
        we && sel == SEL_A |=> coefs.a == $past(wdata));
    a_r7_write_k: assert property (@(posedge clk) disable iff (rst)
        we && sel == SEL_K |=> coefs.k == $past(wdata));
    // R7: unused selector codes leave every constant untouched
    a_r7_unused_sel: assert property (@(posedge clk) disable iff (rst)
        we && sel > 3'd4 |=> $stable(coefs));

endmodule

// File: rtl/logu_norm.sv
module logu_norm
    import logu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [IN_W-1:0] in_data,
    input  coef_t           seed,
    output pipe_t           dout
);

    exp_t            lead;
    logic [IN_W-1:0] aligned;
    logic [FW-1:0]   frac;

    // Leading-one position and left alignment
    always_comb begin
        lead = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (in_data[i]) lead = exp_t'(i);
        end
        aligned = in_data << (IN_W - 1 - int'(lead));
    end

    // Fit the bits below the leading one into FW fraction bits
    generate
        if (FW > IN_W - 1) begin : g_pad
            assign frac = {aligned[IN_W-2:0], {(FW-IN_W+1){1'b0}}};
        end else if (FW == IN_W - 1) begin : g_exact
            assign frac = aligned[IN_W-2:0];
        end else begin : g_trunc
            assign frac = aligned[IN_W-2 -: FW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.vld  <= in_vld;
            dout.zero <= (in_data == '0);
            dout.ex   <= lead;
            dout.mant <= {1'b1, frac};
            dout.acc  <= acc_t'(seed);
        end
    end

    // R1: alignment puts the leading one in the top bit
    a_r1_align_top: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_data != '0 |-> aligned[IN_W-1]);
    // R1: the registered exponent points at the highest set bit
    a_r1_exp_msb: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_data != '0 |=> ($past(in_data) >> dout.ex) == IN_W'(1));
    // R4: a zero input is marked
    a_r4_zero_seen: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_data == '0 |=> dout.zero);

endmodule

// File: rtl/logu_horner_stage.sv
module logu_horner_stage
    import logu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pipe_t din,
    input  coef_t add_coef,
    output pipe_t dout
);

    prod_t prod;
    prod_t scaled;
    acc_t  acc_next;

    always_comb begin
        prod     = din.acc * $signed({1'b0, din.mant});
        scaled   = round_shift(prod);
        acc_next = scaled[AW-1:0] + acc_t'(add_coef);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.vld  <= din.vld;
            dout.zero <= din.zero;
            dout.ex   <= din.ex;
            dout.mant <= din.mant;
            dout.acc  <= acc_next;
        end
    end

    // R5: every stage passes its qualifier on after exactly one cycle
    a_r5_stage_step: assert property (@(posedge clk) disable iff (rst)
        dout.vld == $past(din.vld));
    // R2: the rounded product fits the accumulator (no silent wrap)
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        din.vld |-> (scaled[PW-1:AW-1] == '0 || scaled[PW-1:AW-1] == '1));
    // R1: a non-zero sample keeps a normalised mantissa through the stage
    a_r1_mant_norm: assert property (@(posedge clk) disable iff (rst)
        din.vld && !din.zero |-> din.mant[MW-1]);

endmodule

// File: rtl/logu_log_unit.sv
module logu_log_unit
    import logu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic signed [CW-1:0] cfg_data,
    output logic                 out_valid,
    output logic signed [RW-1:0] out_data,
    output logic                 out_err
);

    coef_set_t cs;
    pipe_t     stg [0:3];
    coef_t     add_c [0:2];
    res_t      oct_term;
    res_t      res_next;
    logic [CNT_W-1:0] since_rst;

    logu_coef_bank u_coef (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_data),
        .coefs (cs)
    );

    // Normaliser seeds the accumulator with the cubic coefficient
    logu_norm u_norm (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_data (in_data),
        .seed    (cs.d),
        .dout    (stg[0])
    );

    // Horner order: c, then b, then a
    always_comb begin
        add_c[0] = cs.c;
        add_c[1] = cs.b;
        add_c[2] = cs.a;
    end

    generate
        for (genvar i = 0; i < 3; i++) begin : g_horner
            logu_horner_stage u_stage (
                .clk      (clk),
                .rst      (rst),
                .din      (stg[i]),
                .add_coef (add_c[i]),
                .dout     (stg[i+1])
            );
        end
    endgenerate

    // Octave term only when the exponent is non-zero
    always_comb begin
        if (stg[3].ex != '0) begin
            oct_term = res_t'($signed({1'b0, stg[3].ex})) * res_t'(cs.k);
        end else begin
            oct_term = '0;
        end
        res_next = res_t'(stg[3].acc) + oct_term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= stg[3].vld;
            out_err   <= stg[3].vld & stg[3].zero;
            if (!stg[3].vld) begin
                out_data <= '0;
            end else if (stg[3].zero) begin
                out_data <= RES_MIN;
            end else begin
                out_data <= res_next;
            end
        end
    end

    // Cycles since reset, saturating at LAT, to bound the latency check
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != CNT_W'(LAT)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R5: fixed latency from input to result
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        since_rst == CNT_W'(LAT) |-> out_valid == $past(in_valid, LAT));
    // R4: a flagged result carries the saturated value
    a_r4_zero_out: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid && out_data == RES_MIN);
    // R6: idle outputs are quiet
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_data == '0 && !out_err);
    // R1: the mantissa reaching the combine stage is still normalised
    a_r1_mant_kept: assert property (@(posedge clk) disable iff (rst)
        stg[3].vld && !stg[3].zero |-> stg[3].mant[MW-1]);

endmodule

// File: tb/test_logu_log_unit.sv
module test_logu_log_unit;
    import logu_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [IN_W-1:0]      in_data = '0;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_sel = '0;
    logic signed [CW-1:0] cfg_data = '0;
    logic                 out_valid;
    logic signed [RW-1:0] out_data;
    logic                 out_err;

    always #10 clk = ~clk;   // 50 MHz

    logu_log_unit i_logu_log_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_err   (out_err)
    );

    typedef struct {
        longint val;
        bit     err;
        int     due;
        int     x;
        string  tag;
    } exp_t_tb;

    exp_t_tb q[$];
    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;
    longint ca = 0, cb = 0, cc = 0, cd = 0, ck = 0;
    string  cur_tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rnd(longint p);
        return (p + (longint'(1) << (FW - 1))) >>> FW;
    endfunction

    function automatic longint model(int x);
        int     e;
        longint m, acc;
        if (x == 0) return -(longint'(1) << (RW - 1));
        e = 0;
        for (int i = 0; i < IN_W; i++) if (x[i]) e = i;
        m   = longint'(x) << (FW - e);
        acc = cd;
        acc = rnd(acc * m) + cc;
        acc = rnd(acc * m) + cb;
        acc = rnd(acc * m) + ca;
        if (e != 0) acc = acc + longint'(e) * ck;
        return acc;
    endfunction

    task automatic send(int x, string tag);
        exp_t_tb s;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = IN_W'(x);
        s.val = model(x);
        s.err = (x == 0);
        s.due = cyc + LAT;
        s.x   = x;
        s.tag = tag;
        q.push_back(s);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_data  = '0;
        end
    endtask

    task automatic write_coef(int sel, longint v);
        @(posedge clk);
        #1;
        cfg_we   = 1'b1;
        cfg_sel  = 3'(sel);
        cfg_data = CW'(v);
        case (sel)
            0: ca = v;
            1: cb = v;
            2: cc = v;
            3: cd = v;
            4: ck = v;
            default: ;   // R7: codes 5..7 change nothing
        endcase
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    function automatic string tag_for(int x);
        if (x == 0) return "R4";
        if (x == 1) return "R3";
        if ((x & (x - 1)) == 0) return "R1";
        return cur_tag;
    endfunction

    // Scoreboard, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                checks++;
                if (!out_valid) begin
                    errors++;
                    $display("FAIL R5 x=%0d out_valid=0 expected 1 at cycle %0d", q[0].x, cyc);
                end else if (longint'(out_data) != q[0].val || out_err != q[0].err) begin
                    errors++;
                    $display("FAIL %s x=%0d got %0d err=%0b expected %0d err=%0b",
                             q[0].tag, q[0].x, out_data, out_err, q[0].val, q[0].err);
                end
                void'(q.pop_front());
            end else begin
                checks++;
                if (out_valid || out_data != '0 || out_err) begin
                    errors++;
                    $display("FAIL R6 idle got valid=%0b data=%0d err=%0b expected 0/0/0",
                             out_valid, out_data, out_err);
                end
            end
        end
    end

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired with %0d results pending, expected 0", q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        checks++;
        if (out_valid || out_data != '0 || out_err) begin
            errors++;
            $display("FAIL R8 reset outputs valid=%0b data=%0d err=%0b expected 0/0/0",
                     out_valid, out_data, out_err);
        end
        mon_en = 1'b1;

        // R8: cleared constants give zero for non-zero inputs
        send(5, "R8");
        send(4095, "R8");
        send(0, "R4");
        send(1, "R8");
        idle(8);

        // Realistic constant set, exhaustive sweep back to back (R2, R1, R3, R4, R5)
        write_coef(0, -7134);
        write_coef(1, 11556);
        write_coef(2, -5931);
        write_coef(3, 1509);
        write_coef(4, 4096);
        idle(2);
        cur_tag = "R2";
        for (int x = 0; x < (1 << IN_W); x++) send(x, tag_for(x));
        idle(8);

        // Full-scale alternating constants stress accumulator growth (R2, R3)
        write_coef(0, 131071);
        write_coef(1, -131072);
        write_coef(2, 131071);
        write_coef(3, -131072);
        write_coef(4, -131072);
        idle(2);
        for (int x = (1 << IN_W) - 1; x >= 0; x--) send(x, tag_for(x));
        idle(8);

        // R7: unused selector codes must not disturb any constant
        write_coef(5, 12345);
        write_coef(6, -1);
        write_coef(7, 777);
        idle(2);
        cur_tag = "R7";
        send(1, "R7");
        send(3, "R7");
        send(2047, "R7");
        send(4095, "R7");
        idle(8);

        // R7: selector 4 reaches only the octave constant
        write_coef(4, 1);
        idle(2);
        send(1, "R7");
        send(2048, "R7");
        send(3000, "R7");
        idle(10);

        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R5 %0d results never appeared, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule